// File: doc/BRIEF.md
# Legacy I/O Configuration Register Bank

This block is the configuration register file of a multi-function legacy peripheral controller. Software reaches it through two byte-wide I/O locations on an ISA-style bus: the lower location (address bit 0 clear) holds an index, and the upper one (address bit 0 set) carries the data for the register that the index names. The block answers only while `cfg_mode` is high. That flag comes from a separate unlock block that recognises the entry key sequence. At all other times writes are dropped and reads return 0xFF.

The register space has two parts. Global registers hold the logical device selector, a device permit mask, the suspend and clock-select controls, and a write-only exit command. A banked set of per-device registers is selected through the logical device number. Each logical device has an activate bit and a 16-bit I/O base. The block drives a registered enable for each device, which is the device's activate bit gated by its permit bit, together with the base. The peripheral functions that use these outputs lie outside this block.

Logical device numbers are 0 floppy, 1 serial port 1, 2 serial port 2, 3 parallel port, 4 infrared, and 5 general-purpose I/O and alternate function.

Top module: `legacy_cfg_regbank`

## Requirements
- R1: While `cfg_mode` is high, a write with `io_a0`=0 loads the index register. A read with `io_a0`=0 returns the index. A read or write with `io_a0`=1 reaches the register that the index selects.
- R2: While `cfg_mode` is low, writes change no register and every read returns 0xFF.
- R3: Index 0x07 holds the logical device number as a full byte that reads back as written. Banked accesses reach the device with that number (0 to 5). When the number is 6 or more, banked writes are dropped and banked reads return 0x00.
- R4: Index 0x23 is the permit mask. Bit 0 is floppy, bit 1 serial 1, bit 2 serial 2, bit 3 parallel and bit 4 infrared. Bits 7:5 read as 0.
- R5: Index 0x24 bit 0 drives `soft_suspend`. Bit 1 drives `clk_sel_48`, where 1 selects 48 MHz and 0 selects 24 MHz. The other bits read as 0.
- R6: Index 0x02 is write-only and reads as 0x00. A write to it with bit 1 set raises `cfg_exit` for exactly one cycle, in the cycle after the write. A write with bit 1 clear leaves `cfg_exit` low.
- R7: Banked index 0x30 bit 0 is the activate bit of the selected device. The other bits read as 0.
- R8: Banked index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base, which is driven on `dev_base[16*n+15:16*n]`.
- R9: `dev_en[n]` is the activate bit of device n ANDed with permit bit n. Device 5 has no permit bit and follows its activate bit alone. `dev_en` changes one cycle after the register write that causes the change.
- R10: After reset every register is 0. `dev_en` is 0, `soft_suspend` and `clk_sel_48` are 0, `cfg_exit` is 0 and `io_rdata` is 0xFF.
- R11: `io_rdata` is registered and holds the read result in the cycle after `io_rd`. An index that names no register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration access allowed (from the unlock block) |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_a0 | input | 1 | 0 selects the index location, 1 selects the data location |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_exit | output | 1 | One-cycle request to leave configuration mode |
| soft_suspend | output | 1 | Software suspend control |
| clk_sel_48 | output | 1 | Input clock select: 1 for 48 MHz, 0 for 24 MHz |
| dev_en | output | 6 | Gated enable, one bit per logical device |
| dev_base | output | 96 | 16-bit I/O base for each device, device n at bits 16n+15:16n |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that the exit command is never written in two consecutive cycles. The bench meets both conditions because every access is a single-cycle strobe followed by at least one idle cycle. The bench also drives `cfg_mode` itself, standing in for the unlock block, and lowers it after the exit pulse.

// File: rtl/legacy_cfg_pkg.sv
package legacy_cfg_pkg;
  localparam int BYTE_W = 8;

  // Global register indices
  localparam logic [BYTE_W-1:0] IX_EXIT    = 8'h02;
  localparam logic [BYTE_W-1:0] IX_LDN     = 8'h07;
  localparam logic [BYTE_W-1:0] IX_PERMIT  = 8'h23;
  localparam logic [BYTE_W-1:0] IX_CLKPM   = 8'h24;
  // Banked register indices
  localparam logic [BYTE_W-1:0] IX_ACT     = 8'h30;
  localparam logic [BYTE_W-1:0] IX_BASE_HI = 8'h60;
  localparam logic [BYTE_W-1:0] IX_BASE_LO = 8'h61;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EXIT,
    SEL_LDN,
    SEL_PERMIT,
    SEL_CLKPM,
    SEL_ACT,
    SEL_BHI,
    SEL_BLO
  } reg_sel_e;
endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
  import legacy_cfg_pkg::*;
(
  input  logic [BYTE_W-1:0] index,
  output reg_sel_e          sel
);
  always_comb begin
    case (index)
      IX_EXIT:    sel = SEL_EXIT;
      IX_LDN:     sel = SEL_LDN;
      IX_PERMIT:  sel = SEL_PERMIT;
      IX_CLKPM:   sel = SEL_CLKPM;
      IX_ACT:     sel = SEL_ACT;
      IX_BASE_HI: sel = SEL_BHI;
      IX_BASE_LO: sel = SEL_BLO;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import legacy_cfg_pkg::*;
#(
  parameter int PERMIT_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   ldn_q,
  output logic [PERMIT_W-1:0] permit_q,
  output logic                susp_q,
  output logic                clk48_q,
  output logic                exit_q,
  output logic [BYTE_W-1:0]   rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q    <= '0;
      permit_q <= '0;
      susp_q   <= 1'b0;
      clk48_q  <= 1'b0;
      exit_q   <= 1'b0;
    end else begin
      exit_q <= wr_en && (sel == SEL_EXIT) && wdata[1];
      if (wr_en) begin
        case (sel)
          SEL_LDN:    ldn_q    <= wdata;
          SEL_PERMIT: permit_q <= wdata[PERMIT_W-1:0];
          SEL_CLKPM: begin
            susp_q  <= wdata[0];
            clk48_q <= wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  // Read-back of the globals; the exit register is write-only.
  always_comb begin
    case (sel)
      SEL_LDN:    rd_byte = ldn_q;
      SEL_PERMIT: rd_byte = BYTE_W'(permit_q);
      SEL_CLKPM:  rd_byte = {{(BYTE_W-2){1'b0}}, clk48_q, susp_q};
      default:    rd_byte = '0;
    endcase
  end

  // R6
  exit_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exit_q |=> !exit_q);

  // R4
  permit_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_PERMIT) |=> permit_q == $past(wdata[PERMIT_W-1:0]));

  // R5
  clk_select_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CLKPM) |=> (clk48_q == $past(wdata[1]) && susp_q == $past(wdata[0])));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import legacy_cfg_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_act,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic              act_q,
  output logic [BASE_W-1:0] base_q
);
  localparam int HI_W = BASE_W - BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (we_act) act_q <= wdata[0];
      if (we_hi)  base_q[BASE_W-1:BYTE_W] <= wdata[HI_W-1:0];
      if (we_lo)  base_q[BYTE_W-1:0] <= wdata;
    end
  end

  // R3
  bank_one_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we_act, we_hi, we_lo}));

  // R7
  activate_load_chk: assert property (@(posedge clk) disable iff (rst)
    we_act |=> act_q == $past(wdata[0]));

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we_hi || we_lo) |=> $stable(base_q));
endmodule

// File: rtl/legacy_cfg_regbank.sv
module legacy_cfg_regbank
  import legacy_cfg_pkg::*;
#(
  parameter int NDEV     = 6,
  parameter int PERMIT_W = 5,
  parameter int BASE_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_mode,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic                   io_a0,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   cfg_exit,
  output logic                   soft_suspend,
  output logic                   clk_sel_48,
  output logic [NDEV-1:0]        dev_en,
  output logic [NDEV*BASE_W-1:0] dev_base
);
  localparam int HI_W = BASE_W - BYTE_W;

  logic              acc_wr, acc_rd, data_wr, ldn_ok;
  logic [BYTE_W-1:0] idx_q, ldn_q, glb_rd;
  logic [PERMIT_W-1:0] permit_q;
  logic [NDEV-1:0]   act_vec, permit_full;
  logic [BASE_W-1:0] base_arr [NDEV];
  logic              bank_act;
  logic [BASE_W-1:0] bank_base;
  reg_sel_e          sel;

  assign acc_wr  = io_wr && cfg_mode;
  assign acc_rd  = io_rd && cfg_mode;
  assign data_wr = acc_wr && io_a0;
  assign ldn_ok  = ldn_q < BYTE_W'(NDEV);

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (acc_wr && !io_a0) idx_q <= io_wdata;
  end

  cfg_index_decode u_decode (
    .index (idx_q),
    .sel   (sel)
  );

  cfg_global_regs #(.PERMIT_W(PERMIT_W)) u_global (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (data_wr),
    .sel      (sel),
    .wdata    (io_wdata),
    .ldn_q    (ldn_q),
    .permit_q (permit_q),
    .susp_q   (soft_suspend),
    .clk48_q  (clk_sel_48),
    .exit_q   (cfg_exit),
    .rd_byte  (glb_rd)
  );

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic hit;
    assign hit = data_wr && (ldn_q == BYTE_W'(g));

    cfg_dev_bank #(.BASE_W(BASE_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we_act (hit && sel == SEL_ACT),
      .we_hi  (hit && sel == SEL_BHI),
      .we_lo  (hit && sel == SEL_BLO),
      .wdata  (io_wdata),
      .act_q  (act_vec[g]),
      .base_q (base_arr[g])
    );

    assign dev_base[g*BASE_W +: BASE_W] = base_arr[g];

    if (g < PERMIT_W) begin : g_gated
      assign permit_full[g] = permit_q[g];
      // R9
      permit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !permit_full[g] |=> !dev_en[g]);
    end else begin : g_free
      assign permit_full[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dev_en <= '0;
    else     dev_en <= act_vec & permit_full;
  end

  // Banked read-back for the selected device; out-of-range numbers give zero.
  always_comb begin
    bank_act  = 1'b0;
    bank_base = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (ldn_ok && ldn_q == BYTE_W'(i)) begin
        bank_act  = act_vec[i];
        bank_base = base_arr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= 8'hFF;
    end else if (io_rd && !cfg_mode) begin
      io_rdata <= 8'hFF;
    end else if (acc_rd) begin
      if (!io_a0) begin
        io_rdata <= idx_q;
      end else begin
        case (sel)
          SEL_ACT: io_rdata <= {{(BYTE_W-1){1'b0}}, bank_act};
          SEL_BHI: io_rdata <= BYTE_W'(bank_base[BASE_W-1 -: HI_W]);
          SEL_BLO: io_rdata <= bank_base[BYTE_W-1:0];
          default: io_rdata <= glb_rd;
        endcase
      end
    end
  end

  // R2
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !cfg_mode) |=> io_rdata == 8'hFF);

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !cfg_mode) |=> ($stable(idx_q) && $stable(ldn_q) && $stable(dev_base)));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (dev_en == '0 && !clk_sel_48 && !soft_suspend && !cfg_exit && io_rdata == 8'hFF));

  // R11
  no_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/test_legacy_cfg_regbank.sv
`timescale 1ns/1ps
module test_legacy_cfg_regbank;
  localparam int NDEV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0, io_wr = 1'b0, io_rd = 1'b0, io_a0 = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic cfg_exit, soft_suspend, clk_sel_48;
  logic [NDEV-1:0] dev_en;
  logic [NDEV*16-1:0] dev_base;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  legacy_cfg_regbank i_legacy_cfg_regbank (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .io_wr(io_wr), .io_rd(io_rd),
    .io_a0(io_a0), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_exit(cfg_exit),
    .soft_suspend(soft_suspend), .clk_sel_48(clk_sel_48), .dev_en(dev_en),
    .dev_base(dev_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One-cycle bus write; returns at the falling edge after the capturing edge.
  task automatic bus_wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_a0 = a0; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a0, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_a0 = a0;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] ix, input logic [7:0] d);
    bus_wr(1'b0, ix);
    bus_wr(1'b1, d);
    @(negedge clk);
  endtask

  task automatic cfg_rd(input logic [7:0] ix, output logic [7:0] d);
    bus_wr(1'b0, ix);
    bus_rd(1'b1, d);
  endtask

  task automatic t_reset();
    chk("R10 rdata", io_rdata, 8'hFF);
    chk("R10 dev_en", dev_en, '0);
    chk("R10 clock/suspend/exit", {clk_sel_48, soft_suspend, cfg_exit}, 3'b000);
    chk("R10 base", dev_base[31:0], 32'h0);
  endtask

  task automatic t_index();
    logic [7:0] d;
    bus_wr(1'b0, 8'h5A);
    bus_rd(1'b0, d);
    chk("R1 index readback", d, 8'h5A);
    bus_rd(1'b1, d);
    chk("R11 unused index reads zero", d, 8'h00);
  endtask

  task automatic t_globals();
    logic [7:0] d;
    cfg_wr(8'h23, 8'hFF);
    cfg_rd(8'h23, d);
    chk("R4 permit reserved bits zero", d, 8'h1F);
    cfg_wr(8'h07, 8'h03);
    cfg_rd(8'h07, d);
    chk("R3 device number readback", d, 8'h03);
    cfg_wr(8'h24, 8'h02);
    chk("R5 48 MHz select", {clk_sel_48, soft_suspend}, 2'b10);
    cfg_rd(8'h24, d);
    chk("R5 readback", d, 8'h02);
    cfg_wr(8'h24, 8'hFD);
    chk("R5 suspend only", {clk_sel_48, soft_suspend}, 2'b01);
    cfg_rd(8'h24, d);
    chk("R5 upper bits zero", d, 8'h01);
  endtask

  task automatic t_device();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h01);
    cfg_wr(8'h30, 8'hFF);
    cfg_rd(8'h30, d);
    chk("R7 activate readback", d, 8'h01);
    cfg_wr(8'h60, 8'h03);
    cfg_wr(8'h61, 8'hF8);
    chk("R8 device 1 base", dev_base[31:16], 16'h03F8);
    chk("R8 device 0 untouched", dev_base[15:0], 16'h0000);
    cfg_rd(8'h60, d);
    chk("R8 high byte readback", d, 8'h03);
    chk("R9 device 1 enabled", dev_en, 6'b000010);
    cfg_wr(8'h07, 8'h05);
    cfg_wr(8'h30, 8'h01);
    chk("R9 device 5 enabled", dev_en, 6'b100010);
  endtask

  task automatic t_permit_gate();
    logic [7:0] d;
    cfg_wr(8'h23, 8'h1D);
    chk("R9 permit cleared gates device 1", dev_en, 6'b100000);
    cfg_wr(8'h07, 8'h01);
    cfg_rd(8'h30, d);
    chk("R9 activate bit kept", d, 8'h01);
    cfg_wr(8'h23, 8'h00);
    chk("R9 device 5 has no permit bit", dev_en, 6'b100000);
    cfg_wr(8'h23, 8'h1F);
    chk("R9 device 1 re-enabled", dev_en, 6'b100010);
  endtask

  task automatic t_bad_ldn();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h07);
    cfg_wr(8'h60, 8'hAB);
    cfg_wr(8'h30, 8'h00);
    cfg_rd(8'h60, d);
    chk("R3 out-of-range bank reads zero", d, 8'h00);
    chk("R3 no base changed", dev_base, {16'h0, 16'h0, 16'h0, 16'h0, 16'h03F8, 16'h0});
    chk("R3 no activate changed", dev_en, 6'b100010);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    bus_wr(1'b0, 8'h61);
    cfg_mode = 1'b0;
    bus_wr(1'b0, 8'h30);
    bus_wr(1'b1, 8'h00);
    bus_rd(1'b0, d);
    chk("R2 locked index read", d, 8'hFF);
    bus_rd(1'b1, d);
    chk("R2 locked data read", d, 8'hFF);
    @(negedge clk);
    chk("R2 locked write kept enable", dev_en, 6'b100010);
    cfg_mode = 1'b1;
    bus_rd(1'b0, d);
    chk("R2 index unchanged after lock", d, 8'h61);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    bus_wr(1'b0, 8'h02);
    bus_wr(1'b1, 8'hFD);
    chk("R6 no exit without bit 1", cfg_exit, 1'b0);
    bus_rd(1'b1, d);
    chk("R6 write-only reads zero", d, 8'h00);
    bus_wr(1'b1, 8'h02);
    chk("R6 exit pulse", cfg_exit, 1'b1);
    @(negedge clk);
    chk("R6 exit pulse one cycle", cfg_exit, 1'b0);
    cfg_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_mode = 1'b1;
    t_index();
    t_globals();
    t_device();
    t_permit_gate();
    t_bad_ldn();
    t_locked();
    t_exit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule